// File: doc/BRIEF.md
# NAND Flash Bus Cycle Decoder

This block is the device-side front end of a parallel NAND flash port. It samples the chip select, the two latch strobes, the write and read strobes, the write-protect pin and the I/O bus with an internal clock. From the pin levels it classifies the current bus cycle, and on the appropriate strobe edges it issues single-cycle internal strobes: a command byte, a complete multi-byte address, write data words with their column index, and read requests whose data the array side returns on `rd_data`.

Every pin passes through a two-stage synchroniser. Chip select, write strobe and read strobe also pass through a stability filter, so a pulse shorter than `FILT_LEN` clock samples has no effect. Program and erase opcodes are refused while the write-protect pin is low. That pin is read at its current level on each command edge and is never held in a register by the write strobe.

Top module: `nand_bus_decoder`

## Requirements
- R1: A command is accepted on a write-strobe rising edge while selected, command latch high, address latch low and read strobe high. `cmd_vld` pulses once and `cmd_byte` holds `io_in[7:0]`. The upper I/O bits are ignored.
- R2: An address byte is taken on a write-strobe rising edge while selected, address latch high, command latch low and read strobe high. Bytes are taken from `io_in[7:0]`. After `ADDR_BYTES` bytes, `addr_vld` pulses once and `addr` holds them little-endian, with the first byte in bits 7:0. No pulse occurs before the last byte.
- R3: Every accepted or rejected command cycle clears the address byte count, the write column and the read column to zero.
- R4: A data word is taken on each write-strobe rising edge while selected, both latches low and read strobe high. `wr_vld` pulses and `wr_data` holds the full `io_in`. `wr_col` is 0 for the first word after a command and rises by one for each later word.
- R5: While selected, write strobe high and both latches low, `io_oe` is 1 and `io_out` equals `rd_data`. Each read-strobe falling edge in that state pulses `rd_req`. `rd_col` is 0 for the first request after a command and rises by one for each later request.
- R6: If the write-protect pin is low at the command edge, a command whose opcode is in `PROT_OPS` (default 8'h80 and 8'h60) pulses `cmd_rej` instead of `cmd_vld`. Other opcodes are accepted. The pin level at the edge decides, not its level when the strobe fell.
- R7: While chip select is high, `io_oe` is 0, `io_out` is 0 and no strobe of any kind is produced.
- R8: A low pulse on the write or read strobe lasting fewer than `FILT_LEN` clock samples produces no strobe.
- R9: Both latches high while selected produces no strobe and sets the sticky `proto_err` flag. The flag stays set until the next command cycle clears it.
- R10: `cyc_type` encodes the current pin state as follows:
  - 0: deselected.
  - 1: command.
  - 2: address.
  - 3: data input, meaning both latches low, write strobe low and read strobe high.
  - 4: data output, meaning both latches low, write strobe high and read strobe low.
  - 5: illegal, meaning both latches high.
  - 6: idle, meaning any other selected state, including a single latch high with the read strobe low.
- R11: After reset all strobes are 0, `proto_err` is 0, `io_oe` is 0 and `cyc_type` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Chip select pin, active low |
| cmd_latch | input | 1 | Command latch pin |
| addr_latch | input | 1 | Address latch pin |
| wr_stb_n | input | 1 | Write strobe pin, captures on rising edge |
| rd_stb_n | input | 1 | Read strobe pin, advances on falling edge |
| wprot_n | input | 1 | Write-protect pin, active low |
| io_in | input | IO_W | I/O bus input |
| io_out | output | IO_W | I/O bus output value |
| io_oe | output | 1 | I/O bus output enable |
| rd_data | input | IO_W | Read word from the array side |
| cmd_vld | output | 1 | Accepted command strobe |
| cmd_rej | output | 1 | Rejected protected command strobe |
| cmd_byte | output | 8 | Last command opcode |
| addr_vld | output | 1 | Complete address strobe |
| addr | output | 8*ADDR_BYTES | Assembled address |
| wr_vld | output | 1 | Write data strobe |
| wr_data | output | IO_W | Write data word |
| wr_col | output | COL_W | Column of the write word |
| rd_req | output | 1 | Read request strobe |
| rd_col | output | COL_W | Column of the read request |
| cyc_type | output | 3 | Current bus cycle class |
| proto_err | output | 1 | Sticky illegal-latch flag |

## Verification
The hardest case to reach is a protected opcode whose write-protect level changes while the write strobe is already low. The command must follow the level at the rising edge, not the level seen when the strobe fell. The bench produces this case by lowering the write strobe with protection off and then asserting protection. It then waits more cycles than the synchroniser and filter latency before releasing the strobe. Sub-threshold pulses are made by holding a strobe low for fewer clock periods than the filter length.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   typedef enum logic [2:0] {
      CYC_STBY = 3'd0,
      CYC_CMD  = 3'd1,
      CYC_ADDR = 3'd2,
      CYC_DIN  = 3'd3,
      CYC_DOUT = 3'd4,
      CYC_ILL  = 3'd5,
      CYC_IDLE = 3'd6
   } nfc_cyc_e;
endpackage

// File: rtl/nfc_pin_sync.sv
module nfc_pin_sync #(
   parameter int W = 1,
   parameter int FILT = 0,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] lvl_o
);
   logic [W-1:0] s1_q, s2_q;

   initial begin
      if (W < 1) $error("nfc_pin_sync: W must be >= 1");
      if (FILT < 0) $error("nfc_pin_sync: FILT must be >= 0");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= RST_VAL;
         s2_q <= RST_VAL;
      end else begin
         s1_q <= pin_i;
         s2_q <= s1_q;
      end
   end

   generate
      if (FILT == 0) begin : g_nofilt
         assign lvl_o = s2_q;
      end else begin : g_filt
         localparam int CNT_W = $clog2(FILT + 1);
         for (genvar b = 0; b < W; b++) begin : g_bit
            logic [CNT_W-1:0] cnt_q;
            logic             out_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  cnt_q <= '0;
                  out_q <= RST_VAL[b];
               end else if (s2_q[b] == out_q) begin
                  cnt_q <= '0;
               end else if (cnt_q == CNT_W'(FILT - 1)) begin
                  cnt_q <= '0;
                  out_q <= s2_q[b];
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            assign lvl_o[b] = out_q;
         end
      end
   endgenerate
endmodule

// File: rtl/nfc_addr_asm.sv
module nfc_addr_asm #(
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          byte_vld_i,
   input  logic [7:0]    byte_i,
   output logic          done_o,
   output logic [NB*8-1:0] addr_o
);
   localparam int CW = (NB > 1) ? $clog2(NB) : 1;

   logic [CW-1:0] cnt_q;
   logic          take;

   initial begin
      if (NB < 1) $error("nfc_addr_asm: NB must be >= 1");
   end

   assign take = byte_vld_i && !clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (clr_i) begin
            cnt_q <= '0;
         end else if (byte_vld_i) begin
            if (cnt_q == CW'(NB - 1)) begin
               cnt_q  <= '0;
               done_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   generate
      for (genvar i = 0; i < NB; i++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               addr_o[i*8 +: 8] <= '0;
            else if (take && cnt_q == CW'(i))
               addr_o[i*8 +: 8] <= byte_i;
         end
      end
   endgenerate
endmodule

// File: rtl/nfc_cmd_gate.sv
module nfc_cmd_gate #(
   parameter int N_PROT = 2,
   parameter logic [N_PROT*8-1:0] PROT_OPS = {8'h60, 8'h80}
) (
   input  logic [7:0] op_i,
   output logic       prot_o
);
   logic [N_PROT-1:0] hit;

   initial begin
      if (N_PROT < 1) $error("nfc_cmd_gate: N_PROT must be >= 1");
   end

   generate
      for (genvar k = 0; k < N_PROT; k++) begin : g_op
         assign hit[k] = (op_i == PROT_OPS[k*8 +: 8]);
      end
   endgenerate

   assign prot_o = |hit;
endmodule

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder
   import nfc_pkg::*;
#(
   parameter int IO_W = 8,
   parameter int ADDR_BYTES = 5,
   parameter int FILT_LEN = 3,
   parameter int COL_W = 12,
   parameter int N_PROT = 2,
   parameter logic [N_PROT*8-1:0] PROT_OPS = {8'h60, 8'h80}
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chip_sel_n,
   input  logic                    cmd_latch,
   input  logic                    addr_latch,
   input  logic                    wr_stb_n,
   input  logic                    rd_stb_n,
   input  logic                    wprot_n,
   input  logic [IO_W-1:0]         io_in,
   output logic [IO_W-1:0]         io_out,
   output logic                    io_oe,
   input  logic [IO_W-1:0]         rd_data,
   output logic                    cmd_vld,
   output logic                    cmd_rej,
   output logic [7:0]              cmd_byte,
   output logic                    addr_vld,
   output logic [8*ADDR_BYTES-1:0] addr,
   output logic                    wr_vld,
   output logic [IO_W-1:0]         wr_data,
   output logic [COL_W-1:0]        wr_col,
   output logic                    rd_req,
   output logic [COL_W-1:0]        rd_col,
   output logic [2:0]              cyc_type,
   output logic                    proto_err
);
   initial begin
      if (IO_W != 8 && IO_W != 16) $error("nand_bus_decoder: IO_W must be 8 or 16");
      if (ADDR_BYTES != 4 && ADDR_BYTES != 5) $error("nand_bus_decoder: ADDR_BYTES must be 4 or 5");
      if (COL_W < 1) $error("nand_bus_decoder: COL_W must be >= 1");
   end

   // filtered strobes: chip select, write, read (idle high)
   logic [2:0]      stb_f;
   logic            ce_f, we_f, re_f;
   // plain synchronised pins: cmd latch, addr latch, write protect
   logic [2:0]      lvl_s;
   logic            cle_s, ale_s, wp_s;
   logic [IO_W-1:0] io_s;

   nfc_pin_sync #(.W(3), .FILT(FILT_LEN), .RST_VAL(3'b111)) u_stb_sync (
      .clk(clk), .rst_n(rst_n),
      .pin_i({chip_sel_n, wr_stb_n, rd_stb_n}), .lvl_o(stb_f));

   nfc_pin_sync #(.W(3), .FILT(0), .RST_VAL(3'b000)) u_lvl_sync (
      .clk(clk), .rst_n(rst_n),
      .pin_i({cmd_latch, addr_latch, wprot_n}), .lvl_o(lvl_s));

   nfc_pin_sync #(.W(IO_W), .FILT(0), .RST_VAL('0)) u_io_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(io_in), .lvl_o(io_s));

   assign {ce_f, we_f, re_f}  = stb_f;
   assign {cle_s, ale_s, wp_s} = lvl_s;

   logic we_q, re_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q <= 1'b1;
         re_q <= 1'b1;
      end else begin
         we_q <= we_f;
         re_q <= re_f;
      end
   end

   logic sel, we_rise, re_fall;
   logic cmd_cyc, adr_cyc, din_cyc, dout_ev, out_mode, prot_hit, blk;

   assign sel      = !ce_f;
   assign we_rise  = we_f && !we_q;
   assign re_fall  = !re_f && re_q;
   assign cmd_cyc  = sel && we_rise && cle_s && !ale_s && re_f;
   assign adr_cyc  = sel && we_rise && ale_s && !cle_s && re_f;
   assign din_cyc  = sel && we_rise && !ale_s && !cle_s && re_f;
   assign out_mode = sel && we_f && !cle_s && !ale_s;
   assign dout_ev  = out_mode && re_fall;

   nfc_cmd_gate #(.N_PROT(N_PROT), .PROT_OPS(PROT_OPS)) u_gate (
      .op_i(io_s[7:0]), .prot_o(prot_hit));

   assign blk = prot_hit && !wp_s;

   nfc_addr_asm #(.NB(ADDR_BYTES)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr_i(cmd_cyc),
      .byte_vld_i(adr_cyc), .byte_i(io_s[7:0]),
      .done_o(addr_vld), .addr_o(addr));

   logic [COL_W-1:0] wcnt_q, rcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_vld   <= 1'b0;
         cmd_rej   <= 1'b0;
         cmd_byte  <= '0;
         wr_vld    <= 1'b0;
         wr_data   <= '0;
         wr_col    <= '0;
         rd_req    <= 1'b0;
         rd_col    <= '0;
         wcnt_q    <= '0;
         rcnt_q    <= '0;
         proto_err <= 1'b0;
      end else begin
         cmd_vld <= cmd_cyc && !blk;
         cmd_rej <= cmd_cyc && blk;
         wr_vld  <= din_cyc;
         rd_req  <= dout_ev;
         if (cmd_cyc) begin
            cmd_byte <= io_s[7:0];
            wcnt_q   <= '0;
            rcnt_q   <= '0;
         end
         if (din_cyc) begin
            wr_data <= io_s;
            wr_col  <= wcnt_q;
            wcnt_q  <= wcnt_q + 1'b1;
         end
         if (dout_ev) begin
            rd_col <= rcnt_q;
            rcnt_q <= rcnt_q + 1'b1;
         end
         if (sel && cle_s && ale_s)
            proto_err <= 1'b1;
         else if (cmd_cyc)
            proto_err <= 1'b0;
      end
   end

   assign io_oe  = out_mode;
   assign io_out = out_mode ? rd_data : '0;

   nfc_cyc_e cyc;
   always_comb begin
      if (!sel)                              cyc = CYC_STBY;
      else if (cle_s && ale_s)               cyc = CYC_ILL;
      else if (cle_s)                        cyc = re_f ? CYC_CMD : CYC_IDLE;
      else if (ale_s)                        cyc = re_f ? CYC_ADDR : CYC_IDLE;
      else if (re_f && !we_f)                cyc = CYC_DIN;
      else if (!re_f && we_f)                cyc = CYC_DOUT;
      else                                   cyc = CYC_IDLE;
   end
   assign cyc_type = cyc;
endmodule

// File: rtl/nand_bus_decoder_chk.sv
module nand_bus_decoder_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_vld,
   input logic cmd_rej,
   input logic addr_vld,
   input logic wr_vld,
   input logic rd_req,
   input logic proto_err,
   input logic cle_s,
   input logic ale_s,
   input logic wp_s,
   input logic ce_f
);
   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_vld, cmd_rej, addr_vld, wr_vld, rd_req}));

   // R9
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(proto_err) |-> $past(cle_s && ale_s));

   // R9
   err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld || cmd_rej) |-> !proto_err);

   // R7
   desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce_f) |-> !(cmd_vld || cmd_rej || addr_vld || wr_vld || rd_req));

   // R6
   rej_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rej |-> $past(!wp_s));

   // R2
   addr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld |=> !addr_vld);
endmodule

bind nand_bus_decoder nand_bus_decoder_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .cmd_vld(cmd_vld), .cmd_rej(cmd_rej), .addr_vld(addr_vld),
   .wr_vld(wr_vld), .rd_req(rd_req), .proto_err(proto_err),
   .cle_s(cle_s), .ale_s(ale_s), .wp_s(wp_s), .ce_f(ce_f));

// File: tb/test_nand_bus_decoder.sv
`timescale 1ns/1ps
module test_nand_bus_decoder;
   localparam int IO_W = 16;
   localparam int NB = 4;
   localparam int FILT = 3;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
   logic [IO_W-1:0] io_in = '0, rd_data = '0;
   logic [IO_W-1:0] io_out, wr_data;
   logic io_oe, cmd_vld, cmd_rej, addr_vld, wr_vld, rd_req, proto_err;
   logic [7:0] cmd_byte;
   logic [8*NB-1:0] addr;
   logic [CW-1:0] wr_col, rd_col;
   logic [2:0] cyc_type;

   always #2 clk = ~clk;

   nand_bus_decoder #(.IO_W(IO_W), .ADDR_BYTES(NB), .FILT_LEN(FILT), .COL_W(CW)) i_nand_bus_decoder (
      .clk(clk), .rst_n(rst_n), .chip_sel_n(ce_n), .cmd_latch(cle), .addr_latch(ale),
      .wr_stb_n(we_n), .rd_stb_n(re_n), .wprot_n(wp_n), .io_in(io_in),
      .io_out(io_out), .io_oe(io_oe), .rd_data(rd_data),
      .cmd_vld(cmd_vld), .cmd_rej(cmd_rej), .cmd_byte(cmd_byte),
      .addr_vld(addr_vld), .addr(addr), .wr_vld(wr_vld), .wr_data(wr_data),
      .wr_col(wr_col), .rd_req(rd_req), .rd_col(rd_col),
      .cyc_type(cyc_type), .proto_err(proto_err));

   int n_chk = 0, n_fail = 0;
   int n_cmd = 0, n_rej = 0, n_adr = 0, n_wr = 0, n_rd = 0;
   logic [7:0] l_cmd;
   logic [8*NB-1:0] l_addr;
   logic [IO_W-1:0] l_wdat;
   logic [CW-1:0] l_wcol, l_rcol;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (cmd_vld) begin n_cmd++; l_cmd = cmd_byte; end
      if (cmd_rej) n_rej++;
      if (addr_vld) begin n_adr++; l_addr = addr; end
      if (wr_vld) begin n_wr++; l_wdat = wr_data; l_wcol = wr_col; end
      if (rd_req) begin n_rd++; l_rcol = rd_col; end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bw(input logic c, input logic a, input logic [IO_W-1:0] d);
      cle = c; ale = a; io_in = d; re_n = 1'b1; we_n = 1'b1;
      clks(8);
      we_n = 1'b0;
      clks(8);
      we_n = 1'b1;
      clks(8);
      cle = 1'b0; ale = 1'b0;
      clks(4);
   endtask

   function automatic int exp_cyc(bit ce, bit c, bit a, bit w, bit r);
      if (ce) return 0;
      if (c && a) return 5;
      if (c) return r ? 1 : 6;
      if (a) return r ? 2 : 6;
      if (r && !w) return 3;
      if (!r && w) return 4;
      return 6;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we_n = 1'b1; re_n = 1'b1;
      clks(3);
      rst_n = 1'b1;
      clks(3);
   endtask

   initial begin
      int c0;
      do_reset();
      // R11 reset state
      chk(!cmd_vld && !cmd_rej && !addr_vld && !wr_vld && !rd_req, "R11 strobes", 0, 0);
      chk(!proto_err && !io_oe, "R11 err/oe", {proto_err, io_oe}, 0);
      chk(cyc_type == 3'd0, "R11 cyc_type", cyc_type, 0);

      // R10 sweep of all pin combinations
      for (int v = 0; v < 32; v++) begin
         ce_n = v[4]; cle = v[3]; ale = v[2]; we_n = v[1]; re_n = v[0];
         clks(10);
         chk(cyc_type == 3'(exp_cyc(v[4], v[3], v[2], v[1], v[0])), "R10 cyc_type",
             cyc_type, exp_cyc(v[4], v[3], v[2], v[1], v[0]));
      end
      do_reset();
      n_cmd = 0; n_rej = 0; n_adr = 0; n_wr = 0; n_rd = 0;
      ce_n = 1'b0; wp_n = 1'b1;
      clks(8);

      // R1 command, upper bits ignored
      bw(1, 0, 16'hAB90);
      chk(n_cmd == 1 && l_cmd == 8'h90, "R1 cmd", l_cmd, 8'h90);

      // R2/R3 address assembly and restart on command
      bw(0, 1, 16'hFF11);
      bw(0, 1, 16'hFF22);
      bw(1, 0, 16'h0000);
      bw(0, 1, 16'h0044);
      bw(0, 1, 16'h0055);
      bw(0, 1, 16'h0066);
      chk(n_adr == 0, "R2 early addr", n_adr, 0);
      bw(0, 1, 16'h0077);
      chk(n_adr == 1, "R2 addr count", n_adr, 1);
      chk(l_addr == 32'h77665544, "R3 addr value", l_addr, 32'h77665544);

      // R4 data input
      bw(0, 0, 16'h1234);
      chk(n_wr == 1 && l_wcol == 0, "R4 first col", l_wcol, 0);
      bw(0, 0, 16'h5678);
      bw(0, 0, 16'h9ABC);
      chk(n_wr == 3 && l_wcol == 2, "R4 col", l_wcol, 2);
      chk(l_wdat == 16'h9ABC, "R4 data", l_wdat, 16'h9ABC);

      // R5 data output
      bw(1, 0, 16'h0030);
      rd_data = 16'hC3A5;
      clks(8);
      chk(io_oe && io_out == 16'hC3A5, "R5 drive", io_out, 16'hC3A5);
      for (int i = 0; i < 3; i++) begin
         re_n = 1'b0; clks(8); re_n = 1'b1; clks(8);
         chk(n_rd == i + 1 && l_rcol == CW'(i), "R5 rd col", l_rcol, i);
      end

      // R8 short pulses ignored
      re_n = 1'b0; clks(2); re_n = 1'b1; clks(10);
      chk(n_rd == 3, "R8 re glitch", n_rd, 3);
      c0 = n_cmd;
      cle = 1'b1; io_in = 16'h0033; clks(8);
      we_n = 1'b0; clks(2); we_n = 1'b1; clks(10);
      cle = 1'b0; clks(4);
      chk(n_cmd == c0, "R8 we glitch", n_cmd, c0);

      // R6 write protect
      wp_n = 1'b0; clks(4);
      bw(1, 0, 16'h0080);
      chk(n_rej == 1 && n_cmd == c0, "R6 reject", n_rej, 1);
      bw(1, 0, 16'h0000);
      chk(n_cmd == c0 + 1, "R6 unprot op", n_cmd, c0 + 1);
      wp_n = 1'b1; clks(4);
      bw(1, 0, 16'h0060);
      chk(n_cmd == c0 + 2 && l_cmd == 8'h60, "R6 allowed", l_cmd, 8'h60);
      cle = 1'b1; io_in = 16'h0060; clks(8);
      we_n = 1'b0; clks(8);
      wp_n = 1'b0; clks(8);
      we_n = 1'b1; clks(8);
      cle = 1'b0; clks(4);
      chk(n_rej == 2 && n_cmd == c0 + 2, "R6 not latched", n_rej, 2);
      wp_n = 1'b1; clks(4);

      // R9 illegal latches
      c0 = n_cmd + n_rej + n_adr + n_wr + n_rd;
      bw(1, 1, 16'h0011);
      chk(n_cmd + n_rej + n_adr + n_wr + n_rd == c0, "R9 no strobe",
          n_cmd + n_rej + n_adr + n_wr + n_rd, c0);
      chk(proto_err, "R9 sticky", proto_err, 1);
      bw(1, 0, 16'h00FF);
      chk(!proto_err, "R9 clear", proto_err, 0);

      // R7 deselect
      ce_n = 1'b1; clks(8);
      c0 = n_cmd;
      bw(1, 0, 16'h0070);
      chk(n_cmd == c0, "R7 no cmd", n_cmd, c0);
      chk(!io_oe && io_out == '0, "R7 tristate", io_out, 0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin repeat (100000) @(posedge clk);
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule